// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block performs the vectored entry into an interrupt handler for a 16-bit real-mode core. A raise request records an 8-bit vector and leaves it pending. When the core reaches an instruction boundary (it has finished one instruction and has not yet fetched the next opcode), the sequencer checks the pending request against the interrupt-enable bit. If the request is allowed, it takes over a word-wide memory port. It saves the old state on the stack and reads the handler address from the vector table in the lowest kilobyte of memory.

The core supplies its current FLAGS, CS, IP, SP and stack-segment values. The sequencer captures them when an entry starts and returns every updated register on a write strobe with its data. A halt request sets a sticky halted flag, which tells the core to stop fetching. From then on the sequencer starts no further entry until reset. A one-cycle completion pulse tells the core to resume fetching at the new CS:IP.

Top module: `rm_irq_entry`

## Requirements
- R1: After reset, mem_req, busy, done, halted and all register write strobes are 0.
- R2: A raise pulse while idle records raise_vec and leaves it pending. An entry starts only in a cycle with fetch_point at 1, and its first memory request appears in the following cycle.
- R3: Each entry makes exactly five memory accesses, in this order: write FLAGS, write CS, read the new CS from physical address vector*4+2, write IP, read the new IP from physical address vector*4. cs_we and ip_we carry the read words.
- R4: FLAGS is written back (flags_we) in the cycle the FLAGS push is granted. The value equals the captured FLAGS with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R5: Each push first lowers SP by 2 (modulo 2^16) and reports it on sp_we/sp_out. It then writes at physical address (SS*16 + SP) modulo 2^20. After an entry, SP is 6 below its captured value.
- R6: Vectors 0 and 2 start whatever the value of flags_in bit 9. Any other vector starts only when flags_in bit 9 is 1, and otherwise stays pending without any memory request.
- R7: done is high for exactly one cycle, the cycle after ip_we. The pending request is cleared by the IP load, so a boundary that follows makes no new request.
- R8: halt_req sets halted from the next cycle until reset. While halted, no new entry starts.
- R9: While mem_req is 1 and mem_gnt is 0, mem_addr, mem_we and mem_wdata hold their values. An access completes in the cycle mem_gnt is 1, and read data is taken from mem_rdata in that cycle.
- R10: A raise while busy is ignored. A second raise while a request is pending and idle replaces the recorded vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise | input | 1 | Interrupt raise pulse |
| raise_vec | input | 8 | Vector number carried by raise |
| halt_req | input | 1 | Request to halt the core |
| fetch_point | input | 1 | Core is at an instruction boundary |
| flags_in | input | 16 | Current FLAGS of the core |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| ss_in | input | 16 | Current stack segment |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Access granted and completed this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_gnt |
| flags_we | output | 1 | FLAGS update strobe |
| flags_out | output | 16 | New FLAGS |
| cs_we | output | 1 | CS update strobe |
| cs_out | output | 16 | New CS |
| ip_we | output | 1 | IP update strobe |
| ip_out | output | 16 | New IP |
| sp_we | output | 1 | SP update strobe |
| sp_out | output | 16 | New SP |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Sticky halted flag |

## Verification
The assertions check on every cycle that a waiting request stays stable, and that done is a single pulse following the IP load. They also check that both table reads fall inside the vector table at the right word offset, that SP strobes only accompany writes, and that a halted idle sequencer never requests memory. Only the bench scenarios can show the order and contents of the five accesses and the cleared FLAGS bits. The same holds for stack wrap-around across the 20-bit space, masking by the enable bit with its two exempt vectors, and the replacement or dropping of raises.

// File: rtl/rm_irq_entry.sv
module rm_irq_entry #(
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        raise,
  input  logic [7:0]  raise_vec,
  input  logic        halt_req,
  input  logic        fetch_point,
  input  logic [15:0] flags_in,
  input  logic [15:0] cs_in,
  input  logic [15:0] ip_in,
  input  logic [15:0] sp_in,
  input  logic [15:0] ss_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [15:0] mem_rdata,
  output logic        flags_we,
  output logic [15:0] flags_out,
  output logic        cs_we,
  output logic [15:0] cs_out,
  output logic        ip_we,
  output logic [15:0] ip_out,
  output logic        sp_we,
  output logic [15:0] sp_out,
  output logic        busy,
  output logic        done,
  output logic        halted
);

  localparam logic [15:0] CLR_MASK = ~((16'd1 << IF_BIT) | (16'd1 << TF_BIT));

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_FL, S_PUSH_CS, S_LOAD_CS, S_PUSH_IP, S_LOAD_IP, S_DONE
  } st_t;

  st_t         st;
  logic        pend, halt_q;
  logic [7:0]  vec;
  logic [15:0] fl_q, cs_q, ip_q, sp_q, ss_q;

  logic        exempt, take, is_push, is_load, step;
  logic [15:0] sp_dec;

  assign exempt  = (vec == 8'd0) || (vec == 8'd2);
  assign take    = (st == S_IDLE) && fetch_point && pend && !halt_q
                   && (flags_in[IF_BIT] || exempt);
  assign is_push = (st == S_PUSH_FL) || (st == S_PUSH_CS) || (st == S_PUSH_IP);
  assign is_load = (st == S_LOAD_CS) || (st == S_LOAD_IP);
  assign step    = (is_push || is_load) && mem_gnt;
  assign sp_dec  = sp_q - 16'd2;

  assign mem_req  = is_push || is_load;
  assign mem_we   = is_push;
  assign mem_addr = is_push ? ({ss_q, 4'b0000} + {4'b0000, sp_dec})
                            : {10'd0, vec, (st == S_LOAD_CS), 1'b0};

  always_comb begin
    case (st)
      S_PUSH_FL: mem_wdata = fl_q;
      S_PUSH_CS: mem_wdata = cs_q;
      S_PUSH_IP: mem_wdata = ip_q;
      default:   mem_wdata = 16'd0;
    endcase
  end

  assign flags_we  = (st == S_PUSH_FL) && mem_gnt;
  assign flags_out = fl_q & CLR_MASK;
  assign cs_we     = (st == S_LOAD_CS) && mem_gnt;
  assign cs_out    = mem_rdata;
  assign ip_we     = (st == S_LOAD_IP) && mem_gnt;
  assign ip_out    = mem_rdata;
  assign sp_we     = is_push && mem_gnt;
  assign sp_out    = sp_dec;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign halted    = halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= 1'b0;
      halt_q <= 1'b0;
      vec    <= 8'd0;
      fl_q   <= 16'd0;
      cs_q   <= 16'd0;
      ip_q   <= 16'd0;
      sp_q   <= 16'd0;
      ss_q   <= 16'd0;
    end else begin
      if (halt_req) halt_q <= 1'b1;
      if (raise && (st == S_IDLE) && !take) begin
        pend <= 1'b1;
        vec  <= raise_vec;
      end
      if (is_push && mem_gnt) sp_q <= sp_dec;
      case (st)
        S_IDLE: if (take) begin
          fl_q <= flags_in;
          cs_q <= cs_in;
          ip_q <= ip_in;
          sp_q <= sp_in;
          ss_q <= ss_in;
          st   <= S_PUSH_FL;
        end
        S_PUSH_FL: if (step) st <= S_PUSH_CS;
        S_PUSH_CS: if (step) st <= S_LOAD_CS;
        S_LOAD_CS: if (step) st <= S_PUSH_IP;
        S_PUSH_IP: if (step) st <= S_LOAD_IP;
        S_LOAD_IP: if (step) begin
          pend <= 1'b0;
          st   <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_ip: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ip_we));

  a_r3_cs_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
    cs_we |-> !mem_we && mem_addr[1:0] == 2'b10 && mem_addr[19:10] == 10'd0);

  a_r3_ip_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ip_we |-> !mem_we && mem_addr[1:0] == 2'b00 && mem_addr[19:10] == 10'd0);

  a_r5_sp_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> mem_we && mem_req);

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !busy |-> !mem_req);

endmodule

// File: tb/rm_irq_entry_tb.sv
`timescale 1ns/1ps
module rm_irq_entry_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raise = 1'b0, halt_req = 1'b0, fetch_point = 1'b0, mem_gnt = 1'b0;
  logic [7:0]  raise_vec = 8'd0;
  logic [15:0] flags_in = 16'd0, cs_in = 16'd0, ip_in = 16'd0, sp_in = 16'd0, ss_in = 16'd0;
  logic [15:0] mem_rdata = 16'd0;
  logic        mem_req, mem_we, flags_we, cs_we, ip_we, sp_we, busy, done, halted;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, flags_out, cs_out, ip_out, sp_out;

  always #2 clk = ~clk;

  rm_irq_entry u_dut (
    .clk(clk), .rst_n(rst_n), .raise(raise), .raise_vec(raise_vec), .halt_req(halt_req),
    .fetch_point(fetch_point), .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in),
    .sp_in(sp_in), .ss_in(ss_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .flags_we(flags_we), .flags_out(flags_out), .cs_we(cs_we), .cs_out(cs_out),
    .ip_we(ip_we), .ip_out(ip_out), .sp_we(sp_we), .sp_out(sp_out),
    .busy(busy), .done(done), .halted(halted));

  typedef struct packed {
    logic [7:0]  vec;
    logic [15:0] fl, cs, ip, sp, ss;
    logic [1:0]  dly;
  } tv_t;

  localparam tv_t TV [6] = '{
    '{vec: 8'h08, fl: 16'h0202, cs: 16'h1234, ip: 16'h5678, sp: 16'h0100, ss: 16'h2000, dly: 2'd0},
    '{vec: 8'h02, fl: 16'h0146, cs: 16'hF000, ip: 16'hFFF0, sp: 16'h8000, ss: 16'h0000, dly: 2'd1},
    '{vec: 8'h00, fl: 16'h0000, cs: 16'h0040, ip: 16'h0010, sp: 16'h0002, ss: 16'h1000, dly: 2'd2},
    '{vec: 8'hFF, fl: 16'hFFFF, cs: 16'hABCD, ip: 16'h0001, sp: 16'h0004, ss: 16'hFFFF, dly: 2'd0},
    '{vec: 8'h21, fl: 16'h0200, cs: 16'h0000, ip: 16'h1000, sp: 16'hFFFE, ss: 16'h3000, dly: 2'd1},
    '{vec: 8'h80, fl: 16'h0B02, cs: 16'h7000, ip: 16'h2222, sp: 16'h4444, ss: 16'h5555, dly: 2'd2}
  };

  int checks = 0, errors = 0;

  function automatic logic [15:0] mdl(input logic [19:0] a);
    return a[15:0] ^ 16'hA55A;
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return ({s, 4'b0000} + {4'b0000, o});
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_raise(input logic [7:0] v);
    @(negedge clk);
    raise = 1'b1; raise_vec = v;
    @(negedge clk);
    raise = 1'b0;
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic service(input logic [7:0] ev, input logic [15:0] fl, cs, ip, sp, ss,
                         input int dly, input bit mid_raise);
    logic        a_we [5];
    logic [19:0] a_ad [5];
    logic [15:0] a_wd [5];
    logic [15:0] g_fl, g_cs, g_ip, g_sp;
    logic [19:0] e_ad [5];
    logic [15:0] e_wd [5];
    int n = 0, nd = 0, wcnt = 0, nsp = 0;
    bit fin = 0;
    logic [15:0] s1, s2, s3;
    g_fl = '0; g_cs = '0; g_ip = '0; g_sp = '0;
    @(negedge clk);
    flags_in = fl; cs_in = cs; ip_in = ip; sp_in = sp; ss_in = ss;
    fetch_point = 1'b1;
    for (int c = 0; c < 60 && !fin; c++) begin
      @(negedge clk);
      raise = (mid_raise && c == 3);
      raise_vec = 8'h77;
      mem_gnt = 1'b0;
      if (mem_req) begin
        if (wcnt >= dly) begin
          mem_gnt = 1'b1; wcnt = 0;
          mem_rdata = mdl(mem_addr);
        end else wcnt++;
      end
      #1;
      if (mem_gnt && n < 5) begin
        a_we[n] = mem_we; a_ad[n] = mem_addr; a_wd[n] = mem_wdata; n++;
      end else if (mem_gnt) n++;
      if (flags_we) g_fl = flags_out;
      if (cs_we) g_cs = cs_out;
      if (ip_we) g_ip = ip_out;
      if (sp_we) begin g_sp = sp_out; nsp++; end
      if (done) begin nd++; fin = 1; end
    end
    mem_gnt = 1'b0; raise = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (done) nd++;
    end
    s1 = sp - 16'd2; s2 = sp - 16'd4; s3 = sp - 16'd6;
    e_ad[0] = phys(ss, s1); e_ad[1] = phys(ss, s2); e_ad[2] = {10'd0, ev, 2'b10};
    e_ad[3] = phys(ss, s3); e_ad[4] = {10'd0, ev, 2'b00};
    e_wd[0] = fl; e_wd[1] = cs; e_wd[2] = 16'd0; e_wd[3] = ip; e_wd[4] = 16'd0;
    chk(n == 5, "R3 access count", n, 5);
    if (n == 5) begin
      for (int k = 0; k < 5; k++) begin
        chk(a_we[k] == (k != 2 && k != 4), "R3 access direction", a_we[k], (k != 2 && k != 4));
        chk(a_ad[k] == e_ad[k], (k == 2 || k == 4) ? "R3 table address" : "R5 stack address",
            a_ad[k], e_ad[k]);
        if (k != 2 && k != 4) chk(a_wd[k] == e_wd[k], "R3 pushed word", a_wd[k], e_wd[k]);
      end
    end
    chk(g_fl == (fl & 16'hFCFF), "R4 flags written", g_fl, fl & 16'hFCFF);
    chk(g_cs == mdl(e_ad[2]), "R3 new CS", g_cs, mdl(e_ad[2]));
    chk(g_ip == mdl(e_ad[4]), "R3 new IP", g_ip, mdl(e_ad[4]));
    chk(g_sp == s3 && nsp == 3, "R5 final SP", {g_sp, 16'(nsp)}, {s3, 16'd3});
    chk(nd == 1, "R7 done pulse count", nd, 1);
    quiet(5, mid_raise ? "R10 raise while busy dropped" : "R7 pending cleared");
    fetch_point = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({mem_req, busy, done, halted, flags_we, cs_we, ip_we, sp_we} == 8'd0,
        "R1 reset state", {mem_req, busy, done, halted, flags_we, cs_we, ip_we, sp_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0 && busy == 1'b0, "R1 idle after reset", {mem_req, busy}, 0);

    for (int i = 0; i < 6; i++) begin
      do_raise(TV[i].vec);
      service(TV[i].vec, TV[i].fl, TV[i].cs, TV[i].ip, TV[i].sp, TV[i].ss, int'(TV[i].dly), i == 4);
    end

    // R2: pending but no boundary -> no request
    flags_in = 16'h0200;
    do_raise(8'h40);
    quiet(4, "R2 waits for boundary");
    service(8'h40, 16'h0200, 16'h1111, 16'h2222, 16'h3000, 16'h0100, 0, 0);

    // R6 masked vector, R10 replacement while pending
    flags_in = 16'h0000;
    do_raise(8'h30);
    do_raise(8'h31);
    @(negedge clk); fetch_point = 1'b1;
    quiet(6, "R6 masked vector stays pending");
    chk(busy == 1'b0, "R6 not busy while masked", busy, 0);
    fetch_point = 1'b0;
    service(8'h31, 16'h0200, 16'h0F0F, 16'h00AA, 16'h0200, 16'h0700, 1, 0);

    // R8 halt
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
    chk(halted == 1'b1, "R8 halted set", halted, 1);
    do_raise(8'h00);
    @(negedge clk); flags_in = 16'h0200; fetch_point = 1'b1;
    quiet(8, "R8 no entry while halted");
    chk(halted == 1'b1, "R8 halted sticky", halted, 1);
    fetch_point = 1'b0;

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(halted == 1'b0 && mem_req == 1'b0, "R1 reset clears halt", {halted, mem_req}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule